// File: doc/BRIEF.md
# Paged Memory Mapper with Kernel/User Contexts

The block translates the 16-bit logical address of an 8-bit CPU into a wider physical address. The logical space is split into four 16 KiB windows. Address bits 15:14 pick one of four page entries, and that entry supplies the physical page number that replaces those two bits. Bits 13:0 pass through unchanged. Entries are loaded by CPU I/O writes to a block of eight ports.

There are two contexts. The kernel context has one set of four entries. The user context has one set of four entries per task, and a task register picks the live set, so a task switch is one I/O write. Each user entry carries a valid flag and an allow flag. In user mode, a memory access through an entry that is not both valid and allowed raises a fault. A write to the mapper's own ports in user mode also raises the fault. The fault output is a one-cycle pulse intended for the CPU's non-maskable interrupt line. The first fault is latched together with its address and task until kernel code clears it. An option pins the top window to physical page 3 for every context, so a full remap then needs only three entry writes.

Typical use: the kernel fills a task's user set, writes the task register and then enters user mode. When a fault pulse arrives, the interrupt logic raises `to_kernel` to return to kernel mode.

Top module: `bank_mapper`

## Requirements
- R1: After reset the block is in kernel mode, the task and edit target are 0 and target the kernel set, the fault status is empty, and every entry of every set maps window n to physical page n. User entries reset valid and allowed.
- R2: `phys_addr` is combinational and equals {page of the live entry selected by cpu_addr[15:14], cpu_addr[13:0]}. The live set is the kernel set in kernel mode and the current task's user set in user mode.
- R3: In kernel mode, a write to port base+n (n = 0..3) stores io_data into entry n of the edit target. The fields are page = io_data[PB_W-1:0], valid = io_data[7] and allow = io_data[6]; the flags apply to user sets only. The new value is live from the next cycle.
- R4: A kernel write to base+4 sets the edit target: io_data[7] = 1 selects a user set and io_data[TASK_W-1:0] is the set index. Entry writes change only the targeted set.
- R5: A kernel write to base+5 loads the task register from io_data[TASK_W-1:0]. In user mode this single write changes which user set translates.
- R6: A kernel write to base+6 loads the mode from io_data[0] (1 = user) from the next cycle. `to_kernel` returns the block to kernel mode on the next cycle and takes priority over a simultaneous mode write.
- R7: In user mode, a memory access (`mem_req`) through an entry that is not both valid and allowed produces a fault pulse on the next cycle. The pulse is one cycle long, even if the access is held.
- R8: In user mode, a write to any of the eight mapper ports changes no state and counts as a fault. Its recorded address is {8'h00, io_addr}.
- R9: A fault pulse happens only when the status is empty. The status then holds the faulting address and task until a kernel write to base+7. Later faults neither pulse nor overwrite the status.
- R10: With FIX_TOP set, window 3 always maps to physical page 3 and never faults. Writes to entry 3 of any set are ignored.
- R11: I/O writes outside the eight-port range have no effect.
- R12: In kernel mode, memory accesses never fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | CPU logical address |
| mem_req | input | 1 | A memory access is in progress this cycle |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 8 | I/O port address |
| io_data | input | 8 | I/O write data |
| to_kernel | input | 1 | Return to kernel mode |
| phys_addr | output | PB_W+14 | Translated physical address |
| fault | output | 1 | One-cycle fault pulse |
| user_mode | output | 1 | High while in user mode |
| flt_valid | output | 1 | Fault status holds a record |
| flt_addr | output | 16 | Address of the recorded fault |
| flt_task | output | TASK_W | Task of the recorded fault |

## Verification
The assertions check on every cycle that the offset bits pass straight through and that the fixed top window stays at page 3. They also check that a fault pulse lasts one cycle and coincides with a filled status, that a filled status keeps its record until cleared, that kernel mode never produces a fault, and that `to_kernel` always leaves user mode. Only the bench's scenarios can show the rest. That covers which set an entry write lands in, the single-write task switch, user-mode port writes being ignored, and out-of-range ports being ignored. The bench checks these with a behavioural model of all mapping sets, compared every clock.

// File: rtl/map_pkg.sv
package map_pkg;
  localparam int NB     = 4;
  localparam int LB_W   = 2;
  localparam int OFS_W  = 14;
  localparam int LA_W   = 16;
  localparam int PORT_W = 3;

  localparam logic [PORT_W-1:0] PO_TARGET = 3'd4;
  localparam logic [PORT_W-1:0] PO_TASK   = 3'd5;
  localparam logic [PORT_W-1:0] PO_MODE   = 3'd6;
  localparam logic [PORT_W-1:0] PO_CLEAR  = 3'd7;

  typedef enum logic {CTX_KERNEL = 1'b0, CTX_USER = 1'b1} ctx_e;
endpackage

// File: rtl/map_ctrl.sv
module map_ctrl
  import map_pkg::*;
#(
  parameter int          TASK_W  = 2,
  parameter logic [7:0]  IO_BASE = 8'h78
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [7:0]        io_addr,
  input  logic [7:0]        io_data,
  input  logic              to_kernel,
  output logic              user_mode,
  output logic [TASK_W-1:0] task_id,
  output logic              tgt_user,
  output logic [TASK_W-1:0] tgt_set,
  output logic              ent_we,
  output logic [LB_W-1:0]   ent_idx,
  output logic              clr,
  output logic              io_viol
);
  ctx_e              mode_q, mode_d;
  logic [TASK_W-1:0] task_q, task_d, tset_q, tset_d;
  logic              tusr_q, tusr_d;
  logic              hit, kwr, mode_en, task_en, tgt_en;
  logic [PORT_W-1:0] off;

  assign hit     = io_wr && (io_addr[7:PORT_W] == IO_BASE[7:PORT_W]);
  assign off     = io_addr[PORT_W-1:0];
  assign kwr     = hit && (mode_q == CTX_KERNEL);
  assign io_viol = hit && (mode_q == CTX_USER);

  always_comb begin
    mode_en = to_kernel || (kwr && off == PO_MODE);
    mode_d  = to_kernel ? CTX_KERNEL : ctx_e'(io_data[0]);
    task_en = kwr && off == PO_TASK;
    task_d  = io_data[TASK_W-1:0];
    tgt_en  = kwr && off == PO_TARGET;
    tusr_d  = io_data[7];
    tset_d  = io_data[TASK_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= CTX_KERNEL;
      task_q <= '0;
      tusr_q <= 1'b0;
      tset_q <= '0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      if (task_en) task_q <= task_d;
      if (tgt_en) begin
        tusr_q <= tusr_d;
        tset_q <= tset_d;
      end
    end
  end

  assign user_mode = (mode_q == CTX_USER);
  assign task_id   = task_q;
  assign tgt_user  = tusr_q;
  assign tgt_set   = tset_q;
  assign ent_we    = kwr && !off[PORT_W-1];
  assign ent_idx   = off[LB_W-1:0];
  assign clr       = kwr && off == PO_CLEAR;
endmodule

// File: rtl/map_store.sv
module map_store
  import map_pkg::*;
#(
  parameter int PB_W    = 6,
  parameter int TASK_W  = 2,
  parameter bit FIX_TOP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              wr_user,
  input  logic [TASK_W-1:0] wr_set,
  input  logic [LB_W-1:0]   wr_idx,
  input  logic [7:0]        wr_data,
  input  logic              user_mode,
  input  logic [TASK_W-1:0] task_id,
  input  logic [LB_W-1:0]   lbank,
  output logic [PB_W-1:0]   pbank,
  output logic              ent_ok
);
  localparam int NSET = 1 << TASK_W;

  logic [PB_W-1:0] kb_q [NB];
  logic [PB_W-1:0] ub_q [NSET][NB];
  logic            uv_q [NSET][NB];
  logic            ua_q [NSET][NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    if (FIX_TOP && b == NB - 1) begin : g_fixed
      assign kb_q[b] = PB_W'(b);
      for (genvar s = 0; s < NSET; s++) begin : g_fset
        assign ub_q[s][b] = PB_W'(b);
        assign uv_q[s][b] = 1'b1;
        assign ua_q[s][b] = 1'b1;
      end
    end else begin : g_reg
      logic k_en;
      assign k_en = we && !wr_user && wr_idx == LB_W'(b);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    kb_q[b] <= PB_W'(b);
        else if (k_en) kb_q[b] <= wr_data[PB_W-1:0];
      end
      for (genvar s = 0; s < NSET; s++) begin : g_set
        logic u_en;
        assign u_en = we && wr_user && wr_set == TASK_W'(s) && wr_idx == LB_W'(b);
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            ub_q[s][b] <= PB_W'(b);
            uv_q[s][b] <= 1'b1;
            ua_q[s][b] <= 1'b1;
          end else if (u_en) begin
            ub_q[s][b] <= wr_data[PB_W-1:0];
            uv_q[s][b] <= wr_data[7];
            ua_q[s][b] <= wr_data[6];
          end
        end
      end
    end
  end

  always_comb begin
    if (user_mode) begin
      pbank  = ub_q[task_id][lbank];
      ent_ok = uv_q[task_id][lbank] && ua_q[task_id][lbank];
    end else begin
      pbank  = kb_q[lbank];
      ent_ok = 1'b1;
    end
  end
endmodule

// File: rtl/map_fault.sv
module map_fault
  import map_pkg::*;
#(
  parameter int TASK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_req,
  input  logic              user_mode,
  input  logic              ent_ok,
  input  logic [LA_W-1:0]   cpu_addr,
  input  logic              io_viol,
  input  logic [7:0]        io_addr,
  input  logic [TASK_W-1:0] task_id,
  input  logic              clr,
  output logic              fault,
  output logic              flt_valid,
  output logic [LA_W-1:0]   flt_addr,
  output logic [TASK_W-1:0] flt_task
);
  logic              mem_bad, detect, rec_en;
  logic              pulse_q, val_q, val_d, val_en;
  logic [LA_W-1:0]   addr_q, addr_d;
  logic [TASK_W-1:0] tsk_q;

  always_comb begin
    mem_bad = mem_req && user_mode && !ent_ok;
    detect  = mem_bad || io_viol;
    rec_en  = detect && !val_q;
    addr_d  = mem_bad ? cpu_addr : {8'h00, io_addr};
    val_en  = rec_en || clr;
    val_d   = rec_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      val_q   <= 1'b0;
      addr_q  <= '0;
      tsk_q   <= '0;
    end else begin
      pulse_q <= rec_en;
      if (val_en) val_q <= val_d;
      if (rec_en) begin
        addr_q <= addr_d;
        tsk_q  <= task_id;
      end
    end
  end

  assign fault     = pulse_q;
  assign flt_valid = val_q;
  assign flt_addr  = addr_q;
  assign flt_task  = tsk_q;
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import map_pkg::*;
#(
  parameter int         PB_W    = 6,
  parameter int         TASK_W  = 2,
  parameter logic [7:0] IO_BASE = 8'h78,
  parameter bit         FIX_TOP = 1'b1,
  localparam int        PA_W    = PB_W + 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic              mem_req,
  input  logic              io_wr,
  input  logic [7:0]        io_addr,
  input  logic [7:0]        io_data,
  input  logic              to_kernel,
  output logic [PA_W-1:0]   phys_addr,
  output logic              fault,
  output logic              user_mode,
  output logic              flt_valid,
  output logic [15:0]       flt_addr,
  output logic [TASK_W-1:0] flt_task
);
  logic [1:0]        rs_q;
  logic              rst_i;
  logic [TASK_W-1:0] task_id, tgt_set;
  logic              tgt_user, ent_we, clr, io_viol, ent_ok;
  logic [LB_W-1:0]   ent_idx;
  logic [PB_W-1:0]   pbank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  map_ctrl #(.TASK_W(TASK_W), .IO_BASE(IO_BASE)) u_ctrl (
    .clk(clk), .rst_n(rst_i), .io_wr(io_wr), .io_addr(io_addr),
    .io_data(io_data), .to_kernel(to_kernel), .user_mode(user_mode),
    .task_id(task_id), .tgt_user(tgt_user), .tgt_set(tgt_set),
    .ent_we(ent_we), .ent_idx(ent_idx), .clr(clr), .io_viol(io_viol)
  );

  map_store #(.PB_W(PB_W), .TASK_W(TASK_W), .FIX_TOP(FIX_TOP)) u_store (
    .clk(clk), .rst_n(rst_i), .we(ent_we), .wr_user(tgt_user),
    .wr_set(tgt_set), .wr_idx(ent_idx), .wr_data(io_data),
    .user_mode(user_mode), .task_id(task_id),
    .lbank(cpu_addr[LA_W-1:OFS_W]), .pbank(pbank), .ent_ok(ent_ok)
  );

  map_fault #(.TASK_W(TASK_W)) u_fault (
    .clk(clk), .rst_n(rst_i), .mem_req(mem_req), .user_mode(user_mode),
    .ent_ok(ent_ok), .cpu_addr(cpu_addr), .io_viol(io_viol),
    .io_addr(io_addr), .task_id(task_id), .clr(clr), .fault(fault),
    .flt_valid(flt_valid), .flt_addr(flt_addr), .flt_task(flt_task)
  );

  assign phys_addr = {pbank, cpu_addr[OFS_W-1:0]};
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk #(
  parameter int PB_W    = 6,
  parameter int TASK_W  = 2,
  parameter bit FIX_TOP = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [15:0]          cpu_addr,
  input logic                 to_kernel,
  input logic [PB_W+13:0]     phys_addr,
  input logic                 fault,
  input logic                 user_mode,
  input logic                 flt_valid,
  input logic [15:0]          flt_addr,
  input logic [TASK_W-1:0]    flt_task
);
  // R2: offset bits pass through untouched
  a_r2_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[13:0] == cpu_addr[13:0]);

  // R7: a fault pulse is never longer than one cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  // R9: a pulse always comes with a filled status record
  a_r9_pulse_records: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> flt_valid);

  // R9: a held record is not overwritten
  a_r9_record_held: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && $past(flt_valid)) |-> ($stable(flt_addr) && $stable(flt_task)));

  // R12: kernel mode produces no fault
  a_r12_kernel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !user_mode |=> !fault);

  // R6: return to kernel always takes effect
  a_r6_to_kernel: assert property (@(posedge clk) disable iff (!rst_n)
    to_kernel |=> !user_mode);

  if (FIX_TOP) begin : g_fix
    // R10: top window pinned to page 3
    a_r10_top_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[15:14] == 2'b11) |-> (phys_addr[PB_W+13:14] == PB_W'(3)));
  end
endmodule

bind bank_mapper bank_mapper_chk #(.PB_W(PB_W), .TASK_W(TASK_W), .FIX_TOP(FIX_TOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .to_kernel(to_kernel),
  .phys_addr(phys_addr), .fault(fault), .user_mode(user_mode),
  .flt_valid(flt_valid), .flt_addr(flt_addr), .flt_task(flt_task)
);

// File: tb/bank_mapper_tb.sv
`timescale 1ns/1ps
module bank_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        mem_req, io_wr, to_kernel;
  logic [7:0]  io_addr, io_data;
  logic [19:0] phys_addr;
  logic        fault, user_mode, flt_valid;
  logic [15:0] flt_addr;
  logic [1:0]  flt_task;

  int checks = 0, errors = 0;
  bit cmp_on = 0, done = 0;

  always #5 clk = ~clk;

  bank_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_req(mem_req),
    .io_wr(io_wr), .io_addr(io_addr), .io_data(io_data), .to_kernel(to_kernel),
    .phys_addr(phys_addr), .fault(fault), .user_mode(user_mode),
    .flt_valid(flt_valid), .flt_addr(flt_addr), .flt_task(flt_task)
  );

  // behavioural reference
  int kb[4];
  int ub[4][4];
  bit uv[4][4], ua[4][4];
  bit m_user, m_tu, m_fv, m_fault;
  int m_task, m_ts, m_fa, m_ft;

  task automatic m_reset();
    for (int i = 0; i < 4; i++) begin
      kb[i] = i;
      for (int s = 0; s < 4; s++) begin ub[s][i] = i; uv[s][i] = 1; ua[s][i] = 1; end
    end
    m_user = 0; m_tu = 0; m_fv = 0; m_fault = 0;
    m_task = 0; m_ts = 0; m_fa = 0; m_ft = 0;
  endtask

  function automatic int exp_phys(input logic [15:0] a);
    int w, pg;
    w = a[15:14];
    if (w == 3) pg = 3;
    else if (m_user) pg = ub[m_task][w];
    else pg = kb[w];
    return pg * 16384 + a[13:0];
  endfunction

  function automatic bit exp_ok(input logic [15:0] a);
    int w;
    w = a[15:14];
    if (!m_user || w == 3) return 1;
    return uv[m_task][w] && ua[m_task][w];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else begin
      bit hit, mbad, det;
      int off;
      hit  = io_wr && io_addr >= 8'h78 && io_addr <= 8'h7F;
      off  = io_addr - 8'h78;
      mbad = mem_req && !exp_ok(cpu_addr);
      det  = mbad || (hit && m_user);
      m_fault = det && !m_fv;
      if (det && !m_fv) begin
        m_fv = 1;
        m_fa = mbad ? cpu_addr : io_addr;
        m_ft = m_task;
      end else if (hit && !m_user && off == 7) m_fv = 0;
      if (hit && !m_user) begin
        if (off < 3) begin
          if (m_tu) begin
            ub[m_ts][off] = io_data[5:0]; uv[m_ts][off] = io_data[7]; ua[m_ts][off] = io_data[6];
          end else kb[off] = io_data[5:0];
        end else if (off == 4) begin m_tu = io_data[7]; m_ts = io_data[1:0]; end
        else if (off == 5) m_task = io_data[1:0];
        else if (off == 6) m_user = io_data[0];
      end
      if (to_kernel) m_user = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    #2;
    chk(phys_addr == 20'(exp_phys(cpu_addr)), "R2 phys_addr", phys_addr, exp_phys(cpu_addr));
    chk(fault == m_fault, "R7 fault", fault, m_fault);
    chk(user_mode == m_user, "R6 user_mode", user_mode, m_user);
    chk(flt_valid == m_fv, "R9 flt_valid", flt_valid, m_fv);
    if (m_fv) begin
      chk(flt_addr == 16'(m_fa), "R9 flt_addr", flt_addr, m_fa);
      chk(flt_task == 2'(m_ft), "R9 flt_task", flt_task, m_ft);
    end
  end

  task automatic io(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); io_wr = 1; io_addr = a; io_data = d;
    @(negedge clk); io_wr = 0; io_addr = 8'h00; io_data = 8'h00;
  endtask

  task automatic acc(input logic [15:0] a, input bit req);
    @(negedge clk); cpu_addr = a; mem_req = req;
  endtask

  task automatic settle();
    @(negedge clk); #3;
  endtask

  initial begin
    rst_n = 1; cpu_addr = 0; mem_req = 0; io_wr = 0; io_addr = 0; io_data = 0; to_kernel = 0;
    #3 rst_n = 0;
    repeat (4) @(posedge clk);
    cmp_on = 1;
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);

    // R1 reset state
    acc(16'h4123, 0); #3;
    chk(user_mode == 0 && flt_valid == 0 && fault == 0, "R1 reset state", {user_mode, flt_valid, fault}, 0);
    chk(phys_addr == 20'h04123, "R1 identity map", phys_addr, 20'h04123);

    // R3 kernel entry write
    io(8'h79, 8'h0A);
    acc(16'h4005, 1); #3;
    chk(phys_addr == 20'h28005, "R3 kernel entry 1", phys_addr, 20'h28005);
    chk(!fault, "R12 kernel access", fault, 0);

    // R4 fill user set 1
    acc(16'h0000, 0);
    io(8'h7C, 8'h81);
    io(8'h78, 8'hC5);
    io(8'h79, 8'h87);
    io(8'h7A, 8'h00);
    io(8'h7B, 8'hFF);
    #3;
    chk(phys_addr == 20'h00000, "R4 kernel set untouched", phys_addr, 0);

    // R11 out-of-range write
    io(8'h77, 8'h01);
    io(8'h80, 8'h01);
    #3;
    chk(user_mode == 0, "R11 out-of-range ignored", user_mode, 0);

    // R5/R6 task 1 and user mode
    io(8'h7D, 8'h01);
    io(8'h7E, 8'h01);
    #3;
    chk(user_mode == 1, "R6 enter user", user_mode, 1);
    acc(16'h0010, 1); #3;
    chk(phys_addr == 20'h14010, "R5 task 1 page", phys_addr, 20'h14010);
    acc(16'hC000, 1); settle();
    chk(phys_addr == 20'h0C000 && !fault, "R10 top fixed", phys_addr, 20'h0C000);

    // R7 not-allowed entry, held for two cycles
    acc(16'h4000, 1); settle();
    chk(fault == 1, "R7 fault pulse", fault, 1);
    chk(flt_addr == 16'h4000 && flt_task == 1, "R9 record", flt_addr, 16'h4000);
    settle();
    chk(fault == 0, "R7 single cycle", fault, 0);
    acc(16'h8000, 1); settle();
    chk(fault == 0 && flt_addr == 16'h4000, "R9 no overwrite", flt_addr, 16'h4000);
    acc(16'h0000, 0);

    // R6 back to kernel, clear status
    @(negedge clk); to_kernel = 1; @(negedge clk); to_kernel = 0; #3;
    chk(user_mode == 0, "R6 to_kernel", user_mode, 0);
    io(8'h7F, 8'h00); #3;
    chk(flt_valid == 0, "R9 clear", flt_valid, 0);

    // R8 user write to mapper port
    io(8'h7E, 8'h01);
    @(negedge clk); io_wr = 1; io_addr = 8'h7D; io_data = 8'h02;
    @(negedge clk); io_wr = 0; io_addr = 0; io_data = 0; #3;
    chk(fault == 1 && flt_addr == 16'h007D, "R8 port fault", flt_addr, 16'h007D);
    acc(16'h0020, 1); #3;
    chk(phys_addr == 20'h14020, "R8 task unchanged", phys_addr, 20'h14020);
    acc(16'h0000, 0);

    // R6 priority of to_kernel over mode write, R5 task 0
    @(negedge clk); to_kernel = 1; @(negedge clk); to_kernel = 0;
    io(8'h7F, 8'h00);
    io(8'h7D, 8'h00);
    @(negedge clk); io_wr = 1; io_addr = 8'h7E; io_data = 8'h01; to_kernel = 1;
    @(negedge clk); io_wr = 0; io_addr = 0; io_data = 0; to_kernel = 0; #3;
    chk(user_mode == 0, "R6 to_kernel priority", user_mode, 0);
    io(8'h7E, 8'h01);
    acc(16'h8123, 1); settle();
    chk(phys_addr == 20'h08123 && !fault, "R5 task 0 set", phys_addr, 20'h08123);
    acc(16'h0000, 0);
    repeat (3) @(negedge clk);

    done = 1;
    cmp_on = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule